// File: doc/BRIEF.md
# Comparator Output Post-Processor

This block conditions the single raw decision bit of one analog comparator for use by digital logic. The bit can first be inverted, which is used when the comparator's two inputs are exchanged for offset cancellation. The bit then crosses into the clock domain through a two-stage synchronizer and enters a five-sample history register. A selectable majority vote over the newest one, three or five samples forms the filtered state.

An output pin can be left quiet, driven straight from the inverted-or-not raw bit (no clock involved), or driven from the filtered state. A one-cycle interrupt pulse is raised on a chosen condition: any change, a rising change or a falling change of the filtered state. In single-shot operation it can instead be raised at the end of a comparison. Configuration inputs are expected to change only while the block is disabled. Enabling the block starts a fresh fill of the history, and no edge interrupt can fire until the history holds valid samples.

Top module: `cmp_postproc`

## Requirements
- R1: With `swap_inv` high the raw bit is inverted before any processing; with routing code 1 and `enable` high, `pin_out` equals `raw_in ^ swap_inv` in the same cycle.
- R2: Routing code (`route_sel`) 0 and 3 drive `pin_out` low, 1 drives the unsynchronized (possibly inverted) raw bit, 2 drives `filt_state`; with `enable` low `pin_out` is low for every code.
- R3: Filter code (`filt_len`) 1 selects window W=3 (state high when at least 2 samples are high), 2 selects W=5 (at least 3 high), and 0 and all codes 3 to 7 select W=1 (no filtering). After the m-th rising clock edge with `enable` high (m counted from 1 since enable), `filt_state` is the majority of the inverted-or-not raw values sampled at edges m-3 down to m-2-W.
- R4: `filt_state` stays low until m reaches W+3; one clock edge with `enable` low clears the synchronizer, history and filtered state, so every enable starts a new fill.
- R5: Interrupt code (`irq_sel`) 0 makes `irq_pulse` high in the cycle after edge m whenever `filt_state` after edge m differs from its value after edge m-1, but only for m of at least W+4.
- R6: Interrupt code 1 pulses under the same timing only when the filtered state changes from 0 to 1.
- R7: Interrupt code 2 pulses under the same timing only when the filtered state changes from 1 to 0.
- R8: Interrupt code 3 pulses, combinationally, in a cycle where `conv_done` is high while it was low at the previous clock edge, provided `enable` and `single_mode` are high; with `single_mode` low it never pulses, and for codes 0 to 2 `conv_done` has no effect.
- R9: While `rst` is high and in the cycle after it, `filt_state` and `irq_pulse` are low, and `pin_out` is low for routing code 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low clears the processing history |
| swap_inv | input | 1 | Invert the raw decision (inputs swapped) |
| filt_len | input | 3 | Majority filter code: 0 none, 1 three-sample, 2 five-sample |
| route_sel | input | 2 | Pin routing: 0 off, 1 raw, 2 filtered, 3 off |
| irq_sel | input | 2 | Interrupt condition: 0 change, 1 rise, 2 fall, 3 end of comparison |
| single_mode | input | 1 | 1 for single-shot operation, 0 for continuous |
| raw_in | input | 1 | Raw comparator decision, asynchronous |
| conv_done | input | 1 | Single-shot comparison finished indication |
| pin_out | output | 1 | Routed comparator output |
| filt_state | output | 1 | Synchronized and filtered decision |
| irq_pulse | output | 1 | One-cycle interrupt/event pulse |

## Verification
The hardest situation to reach is the fill window right after enable, where the filtered state first becomes valid and the first edge comparison must be suppressed; it differs in length for each filter code and only recurs after a disable. The stimulus therefore drops `enable` for one edge before every configuration of a sweep over inversion, all eight filter codes, all routing codes and the three edge conditions, and compares every cycle of a pseudo-random raw pattern against a sample-history model. A separate sequence drives `conv_done` in held, repeated and isolated pulses, in single-shot and continuous modes, while the raw bit keeps toggling.

// File: rtl/cmp_pp_pkg.sv
package cmp_pp_pkg;

    // Pin routing codes
    typedef enum logic [1:0] {
        ROUTE_OFF  = 2'd0,
        ROUTE_RAW  = 2'd1,
        ROUTE_FILT = 2'd2,
        ROUTE_RSVD = 2'd3
    } route_e;

    // Interrupt condition codes
    typedef enum logic [1:0] {
        EVT_ANY  = 2'd0,
        EVT_RISE = 2'd1,
        EVT_FALL = 2'd2,
        EVT_DONE = 2'd3
    } evt_e;

    // Filter length codes
    localparam logic [2:0] FLT_BYPASS = 3'd0;
    localparam logic [2:0] FLT_MAJ3   = 3'd1;
    localparam logic [2:0] FLT_MAJ5   = 3'd2;

    // Filtered state handed from the filter to the event logic
    typedef struct packed {
        logic cur;    // filtered state now
        logic prev;   // filtered state one cycle earlier
        logic valid;  // both values come from a filled history
    } edge_s;

    // Number of samples voted on for a filter code
    function automatic int window_len(logic [2:0] code);
        case (code)
            FLT_MAJ3: return 3;
            FLT_MAJ5: return 5;
            default:  return 1;
        endcase
    endfunction

endpackage

// File: rtl/cmp_pp_sync.sv
module cmp_pp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sr <= '0;
        end else begin
            sr <= {sr[STAGES-2:0], d};
        end
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/cmp_pp_filter.sv
module cmp_pp_filter
    import cmp_pp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HIST_DEPTH  = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       sample,
    input  logic [2:0] flen,
    output edge_s      ev
);
    localparam int CNT_MAX = SYNC_STAGES + HIST_DEPTH;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [HIST_DEPTH-1:0] hist;
    logic [CNT_W-1:0]      fill_cnt;
    int                    win;
    int                    ones;
    logic                  ready;
    logic                  vote;
    logic                  state_q;
    logic                  prev_q;
    logic                  armed_q;
    logic                  cmp_ok_q;

    // Effective window, clamped to the history depth
    always_comb begin
        win = window_len(flen);
        if (win > HIST_DEPTH) begin
            win = HIST_DEPTH;
        end
    end

    // Majority over the newest win samples
    always_comb begin
        ones = 0;
        for (int i = 0; i < HIST_DEPTH; i++) begin
            if (i < win) begin
                ones = ones + int'(hist[i]);
            end
        end
        vote = (2 * ones) > win;
    end

    // History holds win valid samples once the synchronizer has filled too
    assign ready = int'(fill_cnt) >= (SYNC_STAGES + win);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hist     <= '0;
            fill_cnt <= '0;
            state_q  <= 1'b0;
            prev_q   <= 1'b0;
            armed_q  <= 1'b0;
            cmp_ok_q <= 1'b0;
        end else begin
            hist <= {hist[HIST_DEPTH-2:0], sample};
            if (int'(fill_cnt) < CNT_MAX) begin
                fill_cnt <= fill_cnt + 1'b1;
            end
            if (ready) begin
                state_q <= vote;
            end
            prev_q   <= state_q;
            armed_q  <= ready;
            cmp_ok_q <= armed_q;
        end
    end

    assign ev.cur   = state_q;
    assign ev.prev  = prev_q;
    assign ev.valid = cmp_ok_q;
endmodule

// File: rtl/cmp_pp_irq.sv
module cmp_pp_irq
    import cmp_pp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       single,
    input  logic [1:0] sel,
    input  edge_s      ev,
    input  logic       done,
    output logic       pulse
);
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            done_q <= 1'b0;
        end else begin
            done_q <= done;
        end
    end

    always_comb begin
        pulse = 1'b0;
        if (en) begin
            case (evt_e'(sel))
                EVT_ANY:  pulse = ev.valid && (ev.cur != ev.prev);
                EVT_RISE: pulse = ev.valid && ev.cur && !ev.prev;
                EVT_FALL: pulse = ev.valid && !ev.cur && ev.prev;
                EVT_DONE: pulse = single && done && !done_q;
                default:  pulse = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cmp_postproc.sv
module cmp_postproc
    import cmp_pp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HIST_DEPTH  = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       swap_inv,
    input  logic [2:0] filt_len,
    input  logic [1:0] route_sel,
    input  logic [1:0] irq_sel,
    input  logic       single_mode,
    input  logic       raw_in,
    input  logic       conv_done,
    output logic       pin_out,
    output logic       filt_state,
    output logic       irq_pulse
);
    logic  pol;
    logic  synced;
    edge_s ev;

    // Inversion for swapped inputs comes before everything else
    assign pol = raw_in ^ swap_inv;

    cmp_pp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .en  (enable),
        .d   (pol),
        .q   (synced)
    );

    cmp_pp_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .HIST_DEPTH  (HIST_DEPTH)
    ) u_filter (
        .clk    (clk),
        .rst    (rst),
        .en     (enable),
        .sample (synced),
        .flen   (filt_len),
        .ev     (ev)
    );

    cmp_pp_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .en     (enable),
        .single (single_mode),
        .sel    (irq_sel),
        .ev     (ev),
        .done   (conv_done),
        .pulse  (irq_pulse)
    );

    always_comb begin
        pin_out = 1'b0;
        if (enable) begin
            case (route_e'(route_sel))
                ROUTE_RAW:  pin_out = pol;
                ROUTE_FILT: pin_out = ev.cur;
                default:    pin_out = 1'b0;
            endcase
        end
    end

    assign filt_state = ev.cur;
endmodule

// File: rtl/cmp_pp_chk.sv
module cmp_pp_chk (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic       swap_inv,
    input logic [1:0] route_sel,
    input logic [1:0] irq_sel,
    input logic       single_mode,
    input logic       raw_in,
    input logic       conv_done,
    input logic       pin_out,
    input logic       filt_state,
    input logic       irq_pulse
);
    AST_RAW_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (enable && route_sel == 2'd1) |-> (pin_out == (raw_in ^ swap_inv))); // R1

    AST_FILT_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (enable && route_sel == 2'd2) |-> (pin_out == filt_state)); // R2

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !filt_state); // R4

    AST_EDGE_IS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (irq_sel != 2'd3 && irq_pulse) |-> (filt_state != $past(filt_state))); // R5

    AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (irq_sel == 2'd1 && irq_pulse) |-> filt_state); // R6

    AST_FALL_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (irq_sel == 2'd2 && irq_pulse) |-> !filt_state); // R7

    AST_CONT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (irq_sel == 2'd3 && !single_mode) |-> !irq_pulse); // R8

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (irq_sel == 2'd3 && irq_pulse) |-> conv_done); // R8

    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (rst)
        (irq_sel == 2'd3 && irq_pulse) |=> !irq_pulse); // R8
endmodule

bind cmp_postproc cmp_pp_chk u_chk (.*);

// File: tb/tb_cmp_postproc.sv
module tb_cmp_postproc;
    logic       clk = 1'b0;
    logic       rst;
    logic       enable;
    logic       swap_inv;
    logic [2:0] filt_len;
    logic [1:0] route_sel;
    logic [1:0] irq_sel;
    logic       single_mode;
    logic       raw_in;
    logic       conv_done;
    logic       pin_out;
    logic       filt_state;
    logic       irq_pulse;

    int   n_checks = 0;
    int   n_fails  = 0;
    logic samp [0:63];
    logic [15:0] lfsr = 16'hACE1;

    localparam int RUN_LEN = 30;

    cmp_postproc dut (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .swap_inv    (swap_inv),
        .filt_len    (filt_len),
        .route_sel   (route_sel),
        .irq_sel     (irq_sel),
        .single_mode (single_mode),
        .raw_in      (raw_in),
        .conv_done   (conv_done),
        .pin_out     (pin_out),
        .filt_state  (filt_state),
        .irq_pulse   (irq_pulse)
    );

    always #4 clk = ~clk;  // 125 MHz

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    function automatic int win_of(input int code);
        if (code == 1) return 3;
        if (code == 2) return 5;
        return 1;
    endfunction

    // Expected filtered state after the m-th enabled edge (R3, R4)
    function automatic logic exp_filt(input int m, input int w);
        int ones = 0;
        if (m < w + 3) return 1'b0;
        for (int j = 0; j < w; j++) ones += int'(samp[m - 3 - j]);
        return (2 * ones) > w;
    endfunction

    task automatic run_cfg(input int sw, input int fl, input int rt, input int is);
        logic f_now;
        logic f_old;
        logic e_irq;
        logic e_pin;
        int   w;
        w = win_of(fl);
        @(negedge clk);
        enable      = 1'b0;
        swap_inv    = sw[0];
        filt_len    = 3'(fl);
        route_sel   = 2'(rt);
        irq_sel     = 2'(is);
        single_mode = 1'b1;
        raw_in      = 1'b1;
        @(negedge clk);
        chk("R4", "filt cleared by disable", filt_state, 1'b0);
        chk("R2", "pin low while disabled", pin_out, 1'b0);
        enable = 1'b1;
        for (int m = 1; m <= RUN_LEN; m++) begin
            raw_in    = next_bit();
            conv_done = next_bit();  // must not matter for codes 0..2 (R8)
            @(posedge clk);
            samp[m] = raw_in ^ sw[0];
            @(negedge clk);
            f_now = exp_filt(m, w);
            f_old = exp_filt(m - 1, w);
            e_irq = 1'b0;
            if (m >= w + 4) begin
                case (is)
                    0: e_irq = (f_now != f_old);
                    1: e_irq = f_now && !f_old;
                    default: e_irq = !f_now && f_old;
                endcase
            end
            case (rt)
                1: e_pin = raw_in ^ sw[0];
                2: e_pin = f_now;
                default: e_pin = 1'b0;
            endcase
            chk(fl == 0 || fl > 2 ? "R3" : (m < w + 3 ? "R4" : "R3"), "filt_state", filt_state, f_now);
            if (rt == 1) chk("R1", "raw route with inversion", pin_out, e_pin);
            else chk("R2", "pin routing", pin_out, e_pin);
            case (is)
                0: chk("R5", "change irq", irq_pulse, e_irq);
                1: chk("R6", "rise irq", irq_pulse, e_irq);
                default: chk("R7", "fall irq", irq_pulse, e_irq);
            endcase
        end
    endtask

    // End-of-comparison interrupt (R8)
    task automatic run_done(input logic single, input int pat);
        logic prevd;
        @(negedge clk);
        enable      = 1'b0;
        irq_sel     = 2'd3;
        filt_len    = 3'd0;
        route_sel   = 2'd2;
        single_mode = single;
        conv_done   = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        prevd  = 1'b0;
        for (int i = 0; i < 16; i++) begin
            raw_in    = ~raw_in;  // filtered edges must not raise code 3
            conv_done = pat[i];
            #1;
            chk("R8", single ? "done pulse" : "continuous silent", irq_pulse,
                single && conv_done && !prevd);
            @(posedge clk);
            prevd = conv_done;
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        rst         = 1'b1;
        enable      = 1'b1;
        swap_inv    = 1'b0;
        filt_len    = 3'd0;
        route_sel   = 2'd2;
        irq_sel     = 2'd0;
        single_mode = 1'b0;
        raw_in      = 1'b1;
        conv_done   = 1'b0;
        samp[0]     = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", "filt in reset", filt_state, 1'b0);
        chk("R9", "irq in reset", irq_pulse, 1'b0);
        chk("R9", "pin in reset", pin_out, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "filt after reset", filt_state, 1'b0);
        chk("R9", "irq after reset", irq_pulse, 1'b0);

        for (int sw = 0; sw < 2; sw++)
            for (int fl = 0; fl < 8; fl++)
                for (int rt = 0; rt < 4; rt++)
                    for (int is = 0; is < 3; is++)
                        run_cfg(sw, fl, rt, is);

        run_done(1'b1, 16'b0010_1101_1001_0110);
        run_done(1'b1, 16'b1111_0000_1110_0011);
        run_done(1'b0, 16'b0101_1010_0110_1001);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule